// File: doc/BRIEF.md
# Line-Synchronous Reference Table Sequencer

This block sets the upper and lower inductor-current limits that a window comparator uses in a power-factor-correcting converter. A line zero-crossing pulse marks the start of each mains half cycle. From that pulse on, an address counter moves one step per sample tick through two precomputed tables. One table holds the upper current bound for every step of the half cycle and the other holds the lower bound. Each table entry is multiplied by a reference magnitude, and the two scaled results go out together with a one-cycle valid strobe.

The magnitude comes from a proportional outer voltage loop that runs once per half cycle. On the clock edge where the zero-crossing pulse is seen, the block takes the difference between the output-voltage setpoint and the measured output voltage. It shifts that difference right by a power-of-two gain and adds it to the magnitude. The new magnitude is clamped into a window set by two inputs. Between zero crossings the magnitude does not change, so every step of a half cycle uses the same scale.

Top module: `refseq_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `lim_valid` is 0 and both limits are 0. The magnitude starts at 1024, which is 0.25 in Q12.
- R2: A cycle with `zc` high reads table entry 0, and the following sample tick reads entry 1.
- R3: Each cycle with `samp_en` high and `zc` low reads the next entry. `lim_valid` is high in exactly the cycle after each read, and the limits belong to that read.
- R4: When no zero crossing arrives, the address stops at entry 255 and every further tick reads entry 255 again.
- R5: Let T(a) be 16·a for a < 128 and 16·(255−a) otherwise. Entry a of the lower table is T(a) and entry a of the upper table is T(a)+256.
- R6: Each limit equals (entry × magnitude) >> 12, which keeps the upper 12 bits of the 24-bit product.
- R7: At a `zc` edge the magnitude becomes magnitude + ((v_set − v_meas) >>> 4), using the `v_meas` value sampled at that edge. The shift is arithmetic and rounds toward minus infinity. The magnitude does not change in any other cycle.
- R8: After an update the magnitude is at most `mag_max` and at least `mag_min`. If the two bounds cross, `mag_min` takes precedence.
- R9: `lim_lo` is never greater than `lim_hi`.
- R10: When `zc` and `samp_en` are high in the same cycle, the zero crossing wins and entry 0 is read.
- R11: In a cycle after one with neither `zc` nor `samp_en`, `lim_valid` is 0 and both limits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample tick, advances the table address |
| zc | input | 1 | Line zero-crossing pulse, restarts the half cycle |
| v_set | input | 12 | Output-voltage setpoint |
| v_meas | input | 12 | Measured output voltage |
| mag_min | input | 12 | Lower clamp for the magnitude |
| mag_max | input | 12 | Upper clamp for the magnitude |
| lim_hi | output | 12 | Scaled upper current limit |
| lim_lo | output | 12 | Scaled lower current limit |
| lim_valid | output | 1 | High for one cycle when new limits are presented |

## Verification
The limits at the ports depend on both the address and the magnitude. If the address counter slips, wraps or misses a restart, a visible step in the triangular profile shows up one cycle after the read it affects. A wrong magnitude scales every limit of the following half cycle, so it appears on the first valid strobe after the zero crossing. This is also how clamping and update faults are detected. The bench walks whole sweeps with both positive and negative voltage errors and compares every strobe with an independent model.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    localparam int LIM_W    = 12;
    localparam int REF_BAND = 256;

    typedef struct packed {
        logic [LIM_W-1:0] hi;
        logic [LIM_W-1:0] lo;
    } lim_pair_t;

    // triangular profile over a half cycle of n entries
    function automatic int profile(input int a, input int n);
        int half;
        int step;
        half = n / 2;
        step = (1 << (LIM_W - 1)) / half;
        return (a < half) ? a * step : (n - 1 - a) * step;
    endfunction

    function automatic int table_entry(input bit upper, input int a, input int n);
        return upper ? profile(a, n) + REF_BAND : profile(a, n);
    endfunction

endpackage

// File: rtl/refseq_addr.sv
module refseq_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zc,
    input  logic              samp_en,
    output logic              rd,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] addr_q
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    assign rd      = zc | samp_en;
    assign rd_addr = zc ? '0 : addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (zc) begin
            addr_q <= ADDR_W'(1);
        end else if (samp_en && addr_q != LAST) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/refseq_rom.sv
module refseq_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12,
    parameter bit UPPER  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rd) begin
            q <= DATA_W'(refseq_pkg::table_entry(UPPER, int'(rd_addr), DEPTH));
        end
    end
endmodule

// File: rtl/refseq_mag.sv
module refseq_mag #(
    parameter int MAG_W    = 12,
    parameter int VOLT_W   = 12,
    parameter int KP_SHIFT = 4,
    parameter int MAG_INIT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zc,
    input  logic [VOLT_W-1:0] v_set,
    input  logic [VOLT_W-1:0] v_meas,
    input  logic [MAG_W-1:0] mag_min,
    input  logic [MAG_W-1:0] mag_max,
    output logic [MAG_W-1:0] mag_q
);
    localparam int SUM_W = MAG_W + 2;
    localparam int EXT_W = SUM_W - (VOLT_W + 1);

    logic signed [VOLT_W:0] err;
    logic signed [VOLT_W:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] capped;
    logic [MAG_W-1:0]        next_mag;

    always_comb begin
        err   = $signed({1'b0, v_set}) - $signed({1'b0, v_meas});
        delta = err >>> KP_SHIFT;
        sum   = $signed({2'b00, mag_q}) + $signed({{EXT_W{delta[VOLT_W]}}, delta});
        capped = sum;
        if (capped > $signed({2'b00, mag_max})) capped = $signed({2'b00, mag_max});
        if (capped < $signed({2'b00, mag_min})) capped = $signed({2'b00, mag_min});
        next_mag = capped[MAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q <= MAG_W'(MAG_INIT);
        end else if (zc) begin
            mag_q <= next_mag;
        end
    end
endmodule

// File: rtl/refseq_scale.sv
module refseq_scale #(
    parameter int DATA_W = 12,
    parameter int MAG_W  = 12
) (
    input  logic [DATA_W-1:0] hi_raw,
    input  logic [DATA_W-1:0] lo_raw,
    input  logic [MAG_W-1:0]  mag,
    output refseq_pkg::lim_pair_t lim
);
    localparam int PROD_W = DATA_W + MAG_W;

    logic [PROD_W-1:0] p_hi;
    logic [PROD_W-1:0] p_lo;
    logic [DATA_W-1:0] s_hi;
    logic [DATA_W-1:0] s_lo;

    always_comb begin
        p_hi   = PROD_W'(hi_raw) * PROD_W'(mag);
        p_lo   = PROD_W'(lo_raw) * PROD_W'(mag);
        s_hi   = DATA_W'(p_hi >> MAG_W);
        s_lo   = DATA_W'(p_lo >> MAG_W);
        lim.hi = s_hi;
        lim.lo = (s_lo > s_hi) ? s_hi : s_lo;
    end
endmodule

// File: rtl/refseq_top.sv
module refseq_top #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = refseq_pkg::LIM_W,
    parameter int MAG_W    = 12,
    parameter int VOLT_W   = 12,
    parameter int KP_SHIFT = 4,
    parameter int MAG_INIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_en,
    input  logic              zc,
    input  logic [VOLT_W-1:0] v_set,
    input  logic [VOLT_W-1:0] v_meas,
    input  logic [MAG_W-1:0]  mag_min,
    input  logic [MAG_W-1:0]  mag_max,
    output logic [DATA_W-1:0] lim_hi,
    output logic [DATA_W-1:0] lim_lo,
    output logic              lim_valid
);
    logic              rd;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [MAG_W-1:0]  mag_q;
    logic [DATA_W-1:0] raw [2];
    logic              vld_q;
    refseq_pkg::lim_pair_t lim;

    refseq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .zc(zc), .samp_en(samp_en),
        .rd(rd), .rd_addr(rd_addr), .addr_q(addr_q)
    );

    // index 0: upper table, index 1: lower table
    for (genvar g = 0; g < 2; g++) begin : g_tbl
        refseq_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPPER(g == 0)) u_rom (
            .clk(clk), .rst(rst), .rd(rd), .rd_addr(rd_addr), .q(raw[g])
        );
    end

    refseq_mag #(
        .MAG_W(MAG_W), .VOLT_W(VOLT_W), .KP_SHIFT(KP_SHIFT), .MAG_INIT(MAG_INIT)
    ) u_mag (
        .clk(clk), .rst(rst), .zc(zc), .v_set(v_set), .v_meas(v_meas),
        .mag_min(mag_min), .mag_max(mag_max), .mag_q(mag_q)
    );

    refseq_scale #(.DATA_W(DATA_W), .MAG_W(MAG_W)) u_scale (
        .hi_raw(raw[0]), .lo_raw(raw[1]), .mag(mag_q), .lim(lim)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= rd;
    end

    assign lim_hi    = lim.hi;
    assign lim_lo    = lim.lo;
    assign lim_valid = vld_q;
endmodule

// File: rtl/refseq_chk.sv
module refseq_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12,
    parameter int MAG_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              zc,
    input logic              samp_en,
    input logic [MAG_W-1:0]  mag_min,
    input logic [MAG_W-1:0]  mag_max,
    input logic [DATA_W-1:0] lim_hi,
    input logic [DATA_W-1:0] lim_lo,
    input logic              lim_valid,
    input logic [ADDR_W-1:0] addr,
    input logic [MAG_W-1:0]  mag
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        zc |=> addr == ADDR_W'(1));

    assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (rst)
        (zc || samp_en) |=> lim_valid);

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (samp_en && !zc && addr == LAST) |=> addr == LAST);

    assert_mag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !zc |=> $stable(mag));

    assert_mag_window_R8: assert property (@(posedge clk) disable iff (rst)
        (zc && mag_min <= mag_max) |=> (mag >= $past(mag_min) && mag <= $past(mag_max)));

    assert_order_R9: assert property (@(posedge clk) disable iff (rst)
        lim_lo <= lim_hi);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(zc || samp_en) |=> (!lim_valid && $stable(lim_hi) && $stable(lim_lo)));
endmodule

bind refseq_top refseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAG_W(MAG_W)) u_chk (
    .clk(clk), .rst(rst), .zc(zc), .samp_en(samp_en),
    .mag_min(mag_min), .mag_max(mag_max),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_valid(lim_valid),
    .addr(addr_q), .mag(mag_q)
);

// File: tb/refseq_top_test.sv
module refseq_top_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic zc = 1'b0;
    logic [11:0] v_set = 12'd1000;
    logic [11:0] v_meas = 12'd1000;
    logic [11:0] mag_min = 12'd256;
    logic [11:0] mag_max = 12'd3072;
    logic [11:0] lim_hi;
    logic [11:0] lim_lo;
    logic        lim_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    int m_addr = 0;
    int m_mag  = 1024;
    int e_hi   = 0;
    int e_lo   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refseq_top uut (
        .clk(clk), .rst(rst), .samp_en(samp_en), .zc(zc),
        .v_set(v_set), .v_meas(v_meas), .mag_min(mag_min), .mag_max(mag_max),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_valid(lim_valid)
    );

    function automatic int tri_val(input int a);
        return (a < 128) ? 16 * a : 16 * (255 - a);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one cycle, update model, check outputs in the next half period
    task automatic cycle(input bit z, input bit s, input string req);
        int a;
        int d;
        @(negedge clk);
        zc = z;
        samp_en = s;
        if (z) begin
            d = (int'(v_set) - int'(v_meas)) >>> 4;
            m_mag = m_mag + d;
            if (m_mag > int'(mag_max)) m_mag = int'(mag_max);
            if (m_mag < int'(mag_min)) m_mag = int'(mag_min);
            a = 0;
            m_addr = 1;
        end else begin
            a = m_addr;
            if (s && m_addr < 255) m_addr++;
        end
        if (z || s) begin
            e_hi = ((tri_val(a) + 256) * m_mag) >> 12;
            e_lo = (tri_val(a) * m_mag) >> 12;
            if (e_lo > e_hi) e_lo = e_hi;
        end
        @(negedge clk);
        zc = 1'b0;
        samp_en = 1'b0;
        check({req, " valid"}, int'(lim_valid), int'(z || s));
        check({req, " hi"}, int'(lim_hi), e_hi);
        check({req, " lo"}, int'(lim_lo), e_lo);
    endtask

    task automatic t_reset();
        check("R1 valid", int'(lim_valid), 0);
        check("R1 hi", int'(lim_hi), 0);
        check("R1 lo", int'(lim_lo), 0);
    endtask

    task automatic t_restart();
        v_set = 12'd1000; v_meas = 12'd1000;
        cycle(1'b1, 1'b0, "R2 entry0");
        cycle(1'b0, 1'b1, "R2 entry1");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 140; i++) cycle(1'b0, 1'b1, "R3 R5 R6 sweep");
        cycle(1'b0, 1'b0, "R11 idle");
        cycle(1'b0, 1'b0, "R11 idle2");
        cycle(1'b0, 1'b1, "R3 after idle");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 130; i++) cycle(1'b0, 1'b1, "R4 run");
        check("R4 model at last", m_addr, 255);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, "R4 held at 255");
    endtask

    task automatic t_mag_update();
        v_set = 12'd2000; v_meas = 12'd1000;
        cycle(1'b1, 1'b0, "R7 positive error");
        v_meas = 12'd4000;
        for (int i = 0; i < 100; i++) cycle(1'b0, 1'b1, "R7 held between zc");
        v_set = 12'd1000; v_meas = 12'd1500;
        cycle(1'b1, 1'b0, "R7 negative error floor");
        for (int i = 0; i < 64; i++) cycle(1'b0, 1'b1, "R7 R9 sweep");
    endtask

    task automatic t_clamp();
        v_set = 12'd4000; v_meas = 12'd0;
        for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, "R8 up");
        check("R8 model max", m_mag, 3072);
        for (int i = 0; i < 64; i++) cycle(1'b0, 1'b1, "R8 at max");
        v_set = 12'd0; v_meas = 12'd4000;
        for (int i = 0; i < 14; i++) cycle(1'b1, 1'b0, "R8 down");
        check("R8 model min", m_mag, 256);
        for (int i = 0; i < 100; i++) cycle(1'b0, 1'b1, "R8 at min");
        mag_min = 12'd2000; mag_max = 12'd1500;
        cycle(1'b1, 1'b0, "R8 crossed bounds");
        for (int i = 0; i < 50; i++) cycle(1'b0, 1'b1, "R8 crossed sweep");
        mag_min = 12'd256; mag_max = 12'd3072;
    endtask

    task automatic t_collide();
        v_set = 12'd1000; v_meas = 12'd1000;
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, "R10 pre");
        cycle(1'b1, 1'b1, "R10 zc wins");
        cycle(1'b0, 1'b1, "R10 next entry1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_restart();
        t_sweep();
        t_saturate();
        t_mag_update();
        t_clamp();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule